// File: doc/BRIEF.md
# Packed Dual-Entry Color Palette

This block is a 256-entry color lookup table for a display pipeline. Software fills it over a simple register bus, one 32-bit word at a time; each word carries two 16-bit color entries, so 128 words cover the whole table. The block keeps every word exactly as written, which means a bus read gives back all 32 bits untouched, including the two bits that the color path does not use.

The pixel side has a lookup port. It takes an 8-bit color index and, one clock later, returns a 24-bit RGB color with a valid strobe. Each entry holds three 5-bit components. Each component is widened to 8 bits by appending three zero bits. The block decodes its own address window on the bus and ignores every access outside that window.

Top module: `duo_palette`

## Requirements
- R1: The palette window is byte addresses 0x200 through 0x3FF, and word n sits at byte address 0x200 + 4n (word index = address bits [8:2]). A write outside the window changes no word. A read outside the window gives bus_rvalid = 0 and bus_rdata = 0 in the following cycle.
- R2: A read inside the window gives bus_rvalid = 1 in the next cycle, with bus_rdata equal to all 32 bits last written to that word, bits 15 and 31 included.
- R3: After reset every word reads as 0 and every index looks up as black (lk_rgb = 0).
- R4: Entry 2n is the low halfword [15:0] of word n, and entry 2n+1 is the high halfword [31:16].
- R5: Within an entry, red is bits [4:0], green is [9:5] and blue is [14:10]. Bit 15 has no effect on the color. lk_rgb is {red, green, blue} at bits [23:16], [15:8] and [7:0]. Each 8-bit component is the 5-bit field shifted left by 3, so its low three bits are 0.
- R6: lk_valid is 1 in exactly the cycles that follow a cycle with lk_req = 1, and lk_rgb is the color for that request. While no request is made, lk_rgb holds its value.
- R7: One bus write updates both entries of its word at the same clock edge. A lookup issued in the cycle right after the write returns the new color.
- R8: If a read and a write reach the same word in the same cycle, the read returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_rvalid | output | 1 | Read data valid (read hit the window) |
| lk_req | input | 1 | Lookup request |
| lk_idx | input | 8 | Color index |
| lk_rgb | output | 24 | Looked-up color {R,G,B} |
| lk_valid | output | 1 | Lookup result valid |

## Verification
The table is filled with three word patterns and then swept over all 128 words and all 256 indices. A multiplicative hash gives each word distinct bits, so it exposes swapped halves, swapped fields and off-by-one word indexing. An all-ones fill sets both intensity bits and shows that they pass unchanged to the bus but never reach a color. A walking-bit fill catches a component shifted by the wrong amount. Further directed cases cover writes and reads at addresses just outside the window, a lookup in the cycle after a write, a read and a write to the same word in one cycle, and a hold period with no requests.

// File: rtl/duo_palette_pkg.sv
package duo_palette_pkg;
  localparam int DEF_ADDR_W = 12;
  localparam int DEF_BASE   = 'h200;
  localparam int DEF_WORDS  = 128;
  localparam int DEF_COMP_W = 5;
  localparam int DEF_OUT_W  = 8;
  localparam int DEF_ENT_W  = 16;

  // which halfword of a stored word an index selects
  typedef enum logic {HALF_LO = 1'b0, HALF_HI = 1'b1} half_e;
endpackage

// File: rtl/duo_palette_win.sv
module duo_palette_win #(
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h200,
  parameter int WORDS  = 128,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  word_idx
);
  localparam logic [ADDR_W-1:0] LO = ADDR_W'(BASE);
  localparam logic [ADDR_W:0]   HI = (ADDR_W+1)'(BASE + WORDS*4);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off      = addr - LO;
    hit      = (addr >= LO) && ({1'b0, addr} < HI);
    word_idx = IDX_W'(off >> 2);
  end
endmodule

// File: rtl/duo_palette_store.sv
module duo_palette_store #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              en_a,
  input  logic [IDX_W-1:0]  addr_a,
  output logic [WORD_W-1:0] q_a,
  input  logic              en_b,
  input  logic [IDX_W-1:0]  addr_b,
  output logic [WORD_W-1:0] q_b
);
  // raw words: no reset, so the array maps onto block RAM
  logic [WORD_W-1:0] mem [WORDS];
  logic [WORD_W-1:0] ram_a, ram_b;
  // per-word written flags: reset makes unwritten words read as black
  logic [WORDS-1:0]  written;
  logic              wr_a, wr_b;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (en_a) ram_a <= mem[addr_a];
    if (en_b) ram_b <= mem[addr_b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      written <= '0;
      wr_a    <= 1'b0;
      wr_b    <= 1'b0;
    end else begin
      if (we) written[waddr] <= 1'b1;
      if (en_a) wr_a <= written[addr_a];
      if (en_b) wr_b <= written[addr_b];
    end
  end

  assign q_a = wr_a ? ram_a : '0;
  assign q_b = wr_b ? ram_b : '0;
endmodule

// File: rtl/duo_palette_widen.sv
module duo_palette_widen #(
  parameter int COMP_W = 5,
  parameter int OUT_W  = 8,
  localparam int PAD_W = OUT_W - COMP_W
) (
  input  logic [3*COMP_W-1:0] fields,
  output logic [3*OUT_W-1:0]  rgb
);
  logic [COMP_W-1:0] red, grn, blu;

  always_comb begin
    red = fields[COMP_W-1:0];
    grn = fields[2*COMP_W-1:COMP_W];
    blu = fields[3*COMP_W-1:2*COMP_W];
    rgb = {red, {PAD_W{1'b0}}, grn, {PAD_W{1'b0}}, blu, {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/duo_palette.sv
module duo_palette
  import duo_palette_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int BASE   = DEF_BASE,
  parameter int WORDS  = DEF_WORDS,
  parameter int ENT_W  = DEF_ENT_W,
  parameter int COMP_W = DEF_COMP_W,
  parameter int OUT_W  = DEF_OUT_W,
  localparam int WORD_W = 2*ENT_W,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int LK_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic              bus_rd_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic              lk_req,
  input  logic [LK_W-1:0]   lk_idx,
  output logic [3*OUT_W-1:0] lk_rgb,
  output logic              lk_valid
);
  logic             hit;
  logic [IDX_W-1:0] word_idx;
  logic [WORD_W-1:0] q_a, q_b;
  half_e            half_q;
  logic [3*COMP_W-1:0] fields;
  logic             unused_intensity;

  duo_palette_win #(.ADDR_W(ADDR_W), .BASE(BASE), .WORDS(WORDS)) u_win (
    .addr(bus_addr), .hit(hit), .word_idx(word_idx)
  );

  duo_palette_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst(rst),
    .we(bus_wr_en && hit), .waddr(word_idx), .wdata(bus_wdata),
    .en_a(bus_rd_en && hit), .addr_a(word_idx), .q_a(q_a),
    .en_b(lk_req), .addr_b(lk_idx[LK_W-1:1]), .q_b(q_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      lk_valid   <= 1'b0;
      half_q     <= HALF_LO;
    end else begin
      bus_rvalid <= bus_rd_en && hit;
      lk_valid   <= lk_req;
      if (lk_req) half_q <= half_e'(lk_idx[0]);
    end
  end

  assign bus_rdata = bus_rvalid ? q_a : '0;

  // intensity bit of each halfword never reaches the color path
  assign unused_intensity = q_b[ENT_W-1] ^ q_b[WORD_W-1];

  always_comb begin
    if (half_q == HALF_HI) fields = q_b[ENT_W+3*COMP_W-1:ENT_W];
    else                   fields = q_b[3*COMP_W-1:0];
  end

  duo_palette_widen #(.COMP_W(COMP_W), .OUT_W(OUT_W)) u_widen (
    .fields(fields), .rgb(lk_rgb)
  );
endmodule

// File: rtl/duo_palette_chk.sv
module duo_palette_chk #(
  parameter int ADDR_W = 12,
  parameter int BASE   = 'h200,
  parameter int WORDS  = 128,
  parameter int OUT_W  = 8,
  parameter int COMP_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_rd_en,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_rvalid,
  input logic [31:0]        bus_rdata,
  input logic               lk_req,
  input logic [3*OUT_W-1:0] lk_rgb,
  input logic               lk_valid
);
  localparam int PAD_W = OUT_W - COMP_W;
  logic in_win;
  assign in_win = (int'(bus_addr) >= BASE) && (int'(bus_addr) < BASE + WORDS*4);

  a_r2_read_hit: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && in_win) |=> bus_rvalid);

  a_r1_read_miss: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd_en && in_win) |=> (!bus_rvalid && bus_rdata == 32'd0));

  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    lk_req |=> lk_valid);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> !lk_valid);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !lk_req |=> $stable(lk_rgb));

  a_r5_low_zero: assert property (@(posedge clk) disable iff (rst)
    lk_valid |-> (lk_rgb[PAD_W-1:0] == '0 && lk_rgb[OUT_W+PAD_W-1:OUT_W] == '0
                  && lk_rgb[2*OUT_W+PAD_W-1:2*OUT_W] == '0));
endmodule

bind duo_palette duo_palette_chk #(
  .ADDR_W(ADDR_W), .BASE(BASE), .WORDS(WORDS), .OUT_W(OUT_W), .COMP_W(COMP_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
  .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .lk_req(lk_req),
  .lk_rgb(lk_rgb), .lk_valid(lk_valid)
);

// File: tb/duo_palette_tb.sv
module duo_palette_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0, bus_rd_en = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        lk_req = 1'b0;
  logic [7:0]  lk_idx = '0;
  logic [23:0] lk_rgb;
  logic        lk_valid;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [128];

  duo_palette u_dut (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .lk_req(lk_req), .lk_idx(lk_idx),
    .lk_rgb(lk_rgb), .lk_valid(lk_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_rgb(input logic [7:0] idx);
    logic [15:0] h;
    h = idx[0] ? model[idx[7:1]][31:16] : model[idx[7:1]][15:0];
    return {h[4:0], 3'b000, h[9:5], 3'b000, h[14:10], 3'b000};
  endfunction

  function automatic logic [31:0] pat(input int p, input int n);
    case (p)
      0: return (32'(n) * 32'h9E3779B1) ^ 32'h13579BDF;
      1: return 32'hFFFFFFFF;
      default: return (32'd1 << (n % 32)) | (32'd1 << ((n + 13) % 32));
    endcase
  endfunction

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic lookup(input logic [7:0] idx, output logic [23:0] c, output logic v);
    @(negedge clk);
    lk_req = 1'b1; lk_idx = idx;
    @(negedge clk);
    lk_req = 1'b0;
    c = lk_rgb; v = lk_valid;
  endtask

  task automatic fill(input int p);
    for (int n = 0; n < 128; n++) begin
      model[n] = pat(p, n);
      bus_write(12'h200 + 12'(4*n), model[n]);
    end
  endtask

  task automatic sweep(input string tag);
    logic [31:0] d; logic v; logic [23:0] c;
    for (int n = 0; n < 128; n++) begin
      bus_read(12'h200 + 12'(4*n), d, v);
      check({tag, " R2 rvalid"}, 32'(v), 32'd1);
      check({tag, " R2 raw word"}, d, model[n]);
    end
    for (int i = 0; i < 256; i++) begin
      lookup(8'(i), c, v);
      check({tag, " R6 lk_valid"}, 32'(v), 32'd1);
      check({tag, " R4/R5 color"}, 32'(c), 32'(exp_rgb(8'(i))));
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d; logic v; logic [23:0] c; logic [31:0] old;
    for (int n = 0; n < 128; n++) model[n] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R3: reset state
    @(negedge clk);
    check("R6 lk_valid idle after reset", 32'(lk_valid), 32'd0);
    check("R1 rvalid idle after reset", 32'(bus_rvalid), 32'd0);
    sweep("R3 reset");

    // R2/R4/R5: three patterns
    fill(0); sweep("p0");
    fill(1); sweep("p1 intensity");
    check("R5 all ones gives F8F8F8", 32'(exp_rgb(8'd7)), 32'h00F8F8F8);
    fill(2); sweep("p2 walking");

    // R1: accesses just outside the window
    bus_write(12'h400, 32'hDEADBEEF);
    bus_write(12'h1FC, 32'hCAFEF00D);
    bus_write(12'h000, 32'h12345678);
    bus_read(12'h200, d, v);
    check("R1 word0 untouched", d, model[0]);
    bus_read(12'h3FC, d, v);
    check("R1 word127 untouched", d, model[127]);
    bus_read(12'h400, d, v);
    check("R1 miss rvalid", 32'(v), 32'd0);
    check("R1 miss rdata", d, 32'd0);
    bus_read(12'h1FC, d, v);
    check("R1 miss below rvalid", 32'(v), 32'd0);
    check("R1 miss below rdata", d, 32'd0);

    // R7: lookups right after a write, both entries of the word
    @(negedge clk);
    model[5] = 32'h7C1F_83E0;
    bus_wr_en = 1'b1; bus_addr = 12'h214; bus_wdata = model[5];
    @(negedge clk);
    bus_wr_en = 1'b0; lk_req = 1'b1; lk_idx = 8'd10;
    @(negedge clk);
    lk_idx = 8'd11;
    check("R7 even entry after write", 32'(lk_rgb), 32'(exp_rgb(8'd10)));
    check("R7 even entry valid", 32'(lk_valid), 32'd1);
    @(negedge clk);
    lk_req = 1'b0;
    check("R7 odd entry after write", 32'(lk_rgb), 32'(exp_rgb(8'd11)));
    c = lk_rgb;

    // R6: output holds with no request
    repeat (3) begin
      @(negedge clk);
      check("R6 lk_valid low without req", 32'(lk_valid), 32'd0);
      check("R6 lk_rgb holds", 32'(lk_rgb), 32'(c));
    end

    // R8: read and write to the same word in one cycle
    old = model[9];
    @(negedge clk);
    bus_wr_en = 1'b1; bus_rd_en = 1'b1; bus_addr = 12'h224; bus_wdata = 32'hA5A5_5A5A;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_rd_en = 1'b0;
    model[9] = 32'hA5A5_5A5A;
    check("R8 read-first data", bus_rdata, old);
    bus_read(12'h224, d, v);
    check("R8 new data afterwards", d, model[9]);

    finish_run();
  end
endmodule